// File: doc/BRIEF.md
# Translation Buffer with Domain Access Check

This block caches virtual-to-physical translations in front of a table-walk engine. Each cycle it can take one lookup request carrying a 32-bit virtual address, a read/write flag and a user/supervisor flag. It searches every cached entry in parallel. An entry maps either a 1 MB section or a 4 KB page. The domain that entry names is then checked against a 16-domain access register, and the entry's own permission code is applied where the domain requires it. One cycle after the request is accepted, the block answers with one of three results: a physical address with its bufferable and cacheable attributes, an abort, or a miss.

On a miss the block raises a walk request with the faulting address and holds it until the walker hands back a refill entry. The refill is written into a round-robin slot. The requester then issues the lookup again. A flush input clears every entry in one cycle. When translation is off, the virtual address is returned unchanged as the physical address.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a flush is asserted and while a walk is outstanding. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the consumer must take. The refill side is accepted only while `walk_req` is high.

Top module: `xlate_tlb`

## Requirements
- R1: After reset `rsp_valid` and `walk_req` are 0, `req_ready` is 1 and every entry is invalid.
- R2: The response to an accepted request appears with `rsp_valid`=1 in the cycle after acceptance. `req_ready` is 0 while `flush` is high or a walk is outstanding.
- R3: A section entry matches when VA[31:20] equals its tag. The physical address is {ptag[19:8], VA[19:0]}, so every offset up to 0xFFFFF in the megabyte maps.
- R4: A page entry matches only when VA[31:12] equals its tag. The physical address is {ptag[19:0], VA[11:0]}. A neighbouring 4 KB page misses.
- R5: The entry's 4-bit domain d selects bits [2d+1:2d] of `dacr`. Code 00 aborts, 01 (client) applies the entry permission, 10 aborts, and 11 (manager) permits any access.
- R6: For client domains the 2-bit permission code works as follows. 00 aborts every access. 01 allows supervisor read/write and aborts user access. 10 allows supervisor read/write and user read, and aborts a user write. 11 allows all access.
- R7: A permitted hit returns the entry's bufferable and cacheable bits. On an abort or a miss, `rsp_pa`, `rsp_buf` and `rsp_cach` are 0.
- R8: A miss gives `rsp_miss`=1. It also raises `walk_req` with `walk_va` equal to the request address, held until the edge where `refill_valid` is high.
- R9: A refill fills slot 0, 1, 2 and so on in turn, wrapping after DEPTH slots. The DEPTH+1-th refill after a flush evicts the first one.
- R10: `flush` invalidates all entries and resets the replacement pointer to slot 0, taking effect at the next edge.
- R11: With `enable`=0, `rsp_pa` equals the request address, with no abort, no miss and zero attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Translation on (1) or pass-through (0) |
| flush | input | 1 | Invalidate all entries |
| dacr | input | 32 | Domain access codes, 2 bits per domain |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_abort | output | 1 | Access denied |
| rsp_miss | output | 1 | No matching entry |
| rsp_buf | output | 1 | Bufferable attribute |
| rsp_cach | output | 1 | Cacheable attribute |
| walk_req | output | 1 | Table walk wanted |
| walk_va | output | 32 | Address to walk |
| refill_valid | input | 1 | Refill entry present |
| refill_section | input | 1 | Refill is a 1 MB section |
| refill_ptag | input | 20 | Physical tag (section uses bits 19:8) |
| refill_domain | input | 4 | Domain number |
| refill_ap | input | 2 | Permission code |
| refill_buf | input | 1 | Bufferable |
| refill_cach | input | 1 | Cacheable |

## Verification
A vector table sweeps the lookup through reads and writes from both privilege levels. It covers a read-only section, a supervisor-only page, a manager-domain page with a deny-all code, a no-access domain and a reserved domain. This separates domain decoding from permission decoding and user handling from write handling. Further addresses probe the last offset in a section and the page next to a cached page, to tell section matching from page matching. Directed runs cover pass-through, flush followed by a miss and walk handshake, and a fill of DEPTH+1 pages. The fill checks which slot round-robin replacement evicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int TAG_W = 20;
  localparam int SEC_W = 12;

  typedef struct packed {
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] ptag;
    logic             section;
    logic [3:0]       dom;
    logic [1:0]       ap;
    logic             bufb;
    logic             cach;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    DOM_NONE    = 2'b00,
    DOM_CLIENT  = 2'b01,
    DOM_RSVD    = 2'b10,
    DOM_MANAGER = 2'b11
  } dom_code_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       we,
  input  tlb_entry_t wentry,
  output tlb_entry_t entries [DEPTH],
  output logic [DEPTH-1:0] valid
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= '0;
      victim <= '0;
    end else if (flush) begin
      valid  <= '0;
      victim <= '0;
    end else if (we) begin
      valid[victim] <= 1'b1;
      victim        <= (victim == LAST) ? '0 : victim + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && !flush && victim == IW'(i)) entries[i] <= wentry;
    end
  end

  // R10: a flush leaves every slot invalid
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid == '0);
  // R9: pointer advances by one per refill, wrapping at the end
  a_r9_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !flush) |=> victim == (($past(victim) == LAST) ? '0 : $past(victim) + 1'b1));
  // R9: a refill marks exactly one more slot valid (when that slot was free)
  a_r9_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !flush && !valid[victim]) |=> $countones(valid) == $countones($past(valid)) + 1);
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  tlb_entry_t       entries [DEPTH],
  input  logic [DEPTH-1:0] valid,
  input  logic [VA_W-1:0]  va,
  output logic             hit,
  output tlb_entry_t       sel
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic sec_eq, page_eq;
    assign sec_eq  = entries[i].vtag[TAG_W-1 -: SEC_W] == va[VA_W-1 -: SEC_W];
    assign page_eq = entries[i].vtag == va[VA_W-1 -: TAG_W];
    assign match[i] = valid[i] && (entries[i].section ? sec_eq : page_eq);
  end

  // lowest index wins when entries overlap
  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) sel = entries[i];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [31:0] dacr,
  input  logic [3:0]  dom,
  input  logic [1:0]  ap,
  input  logic        write,
  input  logic        user,
  output logic        allow
);
  dom_code_e code;
  logic      ap_ok;

  assign code = dom_code_e'(dacr[{dom, 1'b0} +: 2]);

  always_comb begin
    unique case (ap)
      2'b00:   ap_ok = 1'b0;
      2'b01:   ap_ok = !user;
      2'b10:   ap_ok = !user || !write;
      default: ap_ok = 1'b1;
    endcase
  end

  always_comb begin
    unique case (code)
      DOM_CLIENT:  allow = ap_ok;
      DOM_MANAGER: allow = 1'b1;
      default:     allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        flush,
  input  logic [31:0] dacr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic        rsp_abort,
  output logic        rsp_miss,
  output logic        rsp_buf,
  output logic        rsp_cach,
  output logic        walk_req,
  output logic [31:0] walk_va,
  input  logic        refill_valid,
  input  logic        refill_section,
  input  logic [19:0] refill_ptag,
  input  logic [3:0]  refill_domain,
  input  logic [1:0]  refill_ap,
  input  logic        refill_buf,
  input  logic        refill_cach
);
  tlb_entry_t       entries [DEPTH];
  logic [DEPTH-1:0] valid;
  tlb_entry_t       sel, wentry;
  logic             hit, allow, req_fire, refill_we;
  logic [31:0]      xpa;

  assign req_ready = !walk_req && !flush;
  assign req_fire  = req_valid && req_ready;
  assign refill_we = refill_valid && walk_req;

  always_comb begin
    wentry         = '0;
    wentry.vtag    = walk_va[VA_W-1 -: TAG_W];
    wentry.ptag    = refill_ptag;
    wentry.section = refill_section;
    wentry.dom     = refill_domain;
    wentry.ap      = refill_ap;
    wentry.bufb    = refill_buf;
    wentry.cach    = refill_cach;
  end

  tlb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .we(refill_we),
    .wentry(wentry), .entries(entries), .valid(valid)
  );

  tlb_match #(.DEPTH(DEPTH)) u_match (
    .entries(entries), .valid(valid), .va(req_va), .hit(hit), .sel(sel)
  );

  tlb_perm u_perm (
    .dacr(dacr), .dom(sel.dom), .ap(sel.ap), .write(req_write),
    .user(req_user), .allow(allow)
  );

  assign xpa = sel.section ? {sel.ptag[TAG_W-1 -: SEC_W], req_va[VA_W-SEC_W-1:0]}
                           : {sel.ptag, req_va[VA_W-TAG_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_abort <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_buf   <= 1'b0;
      rsp_cach  <= 1'b0;
      walk_req  <= 1'b0;
      walk_va   <= '0;
    end else begin
      rsp_valid <= req_fire;
      if (req_fire) begin
        rsp_pa    <= '0;
        rsp_abort <= 1'b0;
        rsp_miss  <= 1'b0;
        rsp_buf   <= 1'b0;
        rsp_cach  <= 1'b0;
        if (!enable) begin
          rsp_pa <= req_va;
        end else if (!hit) begin
          rsp_miss <= 1'b1;
          walk_req <= 1'b1;
          walk_va  <= req_va;
        end else if (!allow) begin
          rsp_abort <= 1'b1;
        end else begin
          rsp_pa   <= xpa;
          rsp_buf  <= sel.bufb;
          rsp_cach <= sel.cach;
        end
      end
      if (refill_we) walk_req <= 1'b0;
    end
  end

  // R2: no new request is taken while a walk is outstanding
  a_r2_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);
  // R2: response follows acceptance by one cycle
  a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R8: a reported miss always has a walk open
  a_r8_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> walk_req);
  // R8: walk address stays put until refill
  a_r8_walk_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !refill_valid) |=> walk_req && $stable(walk_va));
  // R7: abort and miss never both, and neither carries attributes
  a_r7_clean_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_abort || rsp_miss) |-> !(rsp_abort && rsp_miss) && !rsp_buf && !rsp_cach && rsp_pa == '0);
  // R11: pass-through when translation is off
  a_r11_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !enable) |=> rsp_pa == $past(req_va) && !rsp_abort && !rsp_miss);
endmodule

// File: tb/xlate_tlb_test.sv
`timescale 1ns/1ps
module xlate_tlb_test;
  localparam int DEPTH = 64;
  localparam int NV = 10;

  logic clk = 0, rst_n = 0, enable = 1, flush = 0;
  logic [31:0] dacr = 32'h0000_008D; // d0 client, d1 manager, d2 none, d3 reserved
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_va = '0;
  logic req_ready, rsp_valid, rsp_abort, rsp_miss, rsp_buf, rsp_cach, walk_req;
  logic [31:0] rsp_pa, walk_va;
  logic refill_valid = 0, refill_section = 0, refill_buf = 0, refill_cach = 0;
  logic [19:0] refill_ptag = '0;
  logic [3:0] refill_domain = '0;
  logic [1:0] refill_ap = '0;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  xlate_tlb #(.DEPTH(DEPTH)) uut (.*);

  // vector table: va, write, user, expect abort, expect pa, expect buf, expect cach
  localparam logic [31:0] V_VA [NV] = '{32'h0012_3456, 32'h0012_3456, 32'h0012_3456,
    32'h0040_0ABC, 32'h0040_0ABC, 32'h0050_1FFF, 32'h0065_4321, 32'h001F_FFFF,
    32'h0077_0000, 32'h0010_0000};
  localparam logic V_WR [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 0, 0};
  localparam logic V_US [NV] = '{1, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam logic V_AB [NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 0};
  localparam logic [31:0] V_PA [NV] = '{32'h8002_3456, 32'h0, 32'h8002_3456,
    32'h0, 32'h1234_5ABC, 32'hABCD_EFFF, 32'h0, 32'h800F_FFFF, 32'h0, 32'h8000_0000};
  localparam logic V_BF [NV] = '{1, 0, 1, 0, 0, 0, 0, 1, 0, 1};
  localparam logic V_CA [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0};

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic w, input logic u);
    @(negedge clk);
    req_va = va; req_write = w; req_user = u; req_valid = 1;
    @(posedge clk); #0.5 req_valid = 0;
    @(negedge clk);
  endtask

  task automatic refill(input logic sec, input logic [19:0] pt, input logic [3:0] d,
                        input logic [1:0] ap, input logic b, input logic c);
    @(negedge clk);
    refill_valid = 1; refill_section = sec; refill_ptag = pt;
    refill_domain = d; refill_ap = ap; refill_buf = b; refill_cach = c;
    @(posedge clk); #0.5 refill_valid = 0;
  endtask

  task automatic load(input logic [31:0] va, input logic sec, input logic [19:0] pt,
                      input logic [3:0] d, input logic [1:0] ap, input logic b, input logic c);
    look(va, 0, 0);
    chk(rsp_valid && rsp_miss, "R8 miss flagged", {30'b0, rsp_valid, rsp_miss}, 32'h3);
    chk(walk_req && walk_va == va, "R8 walk address", walk_va, va);
    refill(sec, pt, d, ap, b, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rsp_valid && !walk_req && req_ready, "R1 reset outputs",
        {29'b0, rsp_valid, walk_req, req_ready}, 32'h1);
    rst_n = 1;
    look(32'h0012_3456, 0, 0);
    chk(rsp_miss, "R1 empty after reset", {31'b0, rsp_miss}, 32'h1);
    // R2 ready low while walk pending
    chk(!req_ready, "R2 ready low during walk", {31'b0, req_ready}, 32'h0);
    refill(1, 20'h80000, 4'd0, 2'b10, 1, 0);
    @(negedge clk);
    chk(!walk_req && req_ready, "R8 walk closed by refill", {30'b0, walk_req, req_ready}, 32'h1);

    load(32'h0040_0000, 0, 20'h12345, 4'd0, 2'b01, 0, 1);
    load(32'h0050_1000, 0, 20'hABCDE, 4'd1, 2'b00, 0, 1);
    load(32'h0060_0000, 1, 20'h55500, 4'd2, 2'b11, 1, 1);
    load(32'h0070_0000, 1, 20'h66600, 4'd3, 2'b11, 1, 1);

    // vector walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      look(V_VA[i], V_WR[i], V_US[i]);
      chk(rsp_valid && !rsp_miss, "R2 R3 R4 hit response", {30'b0, rsp_valid, rsp_miss}, 32'h2);
      chk(rsp_abort == V_AB[i], "R5 R6 abort decision", {31'b0, rsp_abort}, {31'b0, V_AB[i]});
      chk(rsp_pa == V_PA[i], "R3 R4 R7 physical address", rsp_pa, V_PA[i]);
      chk(rsp_buf == V_BF[i] && rsp_cach == V_CA[i], "R7 attributes",
          {30'b0, rsp_buf, rsp_cach}, {30'b0, V_BF[i], V_CA[i]});
    end
    // R2: pulse lasts one cycle
    @(negedge clk);
    chk(!rsp_valid, "R2 single-cycle response", {31'b0, rsp_valid}, 32'h0);

    // R4 neighbour page misses
    look(32'h0040_1000, 0, 0);
    chk(rsp_miss && rsp_pa == 0, "R4 neighbour page miss", rsp_pa, 32'h0);
    refill(0, 20'h00001, 4'd1, 2'b11, 0, 0);
    look(32'h0040_1008, 1, 1);
    chk(!rsp_miss && rsp_pa == 32'h0000_1008, "R4 refilled page", rsp_pa, 32'h0000_1008);

    // R11 pass-through
    enable = 0;
    look(32'hDEAD_BEEF, 1, 1);
    chk(rsp_pa == 32'hDEAD_BEEF && !rsp_abort && !rsp_miss && !walk_req,
        "R11 pass-through", rsp_pa, 32'hDEAD_BEEF);
    enable = 1;

    // R10 flush
    @(negedge clk); flush = 1; #0.5;
    chk(!req_ready, "R2 ready low during flush", {31'b0, req_ready}, 32'h0);
    @(negedge clk); flush = 0;
    look(32'h0012_3456, 0, 0);
    chk(rsp_miss, "R10 flushed entry misses", {31'b0, rsp_miss}, 32'h1);
    refill(0, 20'h00000, 4'd1, 2'b11, 0, 0); // slot 0 <- page 0x00123
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;

    // R9 round robin: fill DEPTH pages then one more
    for (int i = 0; i < DEPTH; i++)
      load(32'h1000_0000 + i * 32'h1000, 0, 20'h40000 + 20'(i), 4'd1, 2'b11, 0, 0);
    load(32'h2000_0000, 0, 20'h7FFFF, 4'd1, 2'b11, 0, 0);
    look(32'h1000_1004, 0, 0);
    chk(!rsp_miss && rsp_pa == 32'h4000_1004, "R9 second slot kept", rsp_pa, 32'h4000_1004);
    look(32'h2000_0010, 0, 0);
    chk(!rsp_miss && rsp_pa == 32'h7FFF_F010, "R9 newest entry", rsp_pa, 32'h7FFF_F010);
    look(32'h1000_0000, 0, 0);
    chk(rsp_miss, "R9 oldest evicted", {31'b0, rsp_miss}, 32'h1);
    refill(0, 20'h40000, 4'd1, 2'b11, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule